// File: doc/BRIEF.md
# ADC Sample Dump Packet Framer

This block turns one snapshot of several 10-bit analog readings into a byte stream for a serial host link. A one-cycle start pulse copies every channel value into an internal snapshot. The block then sends a frame through a valid/ready byte port, which can feed a UART transmitter directly.

A frame starts with a bare type byte. Each channel follows, in ascending index order, as two bytes: the high byte carries the top two sample bits and the low byte carries the bottom eight. A two-byte closing marker ends the frame. The consumer throttles the stream through `ready_i`. While a frame is in flight, the block ignores further start pulses and any change on the sample inputs.

Top module: `adc_dump_framer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after its release, `valid_o` and `busy_o` are 0.
- R2: The first byte of every frame is the type code 8'hA0, presented with `valid_o` high in the cycle after the accepted start pulse.
- R3: For each channel, the first of its two bytes is {6'b0, sample[9:8]}.
- R4: The second byte of each channel pair is sample[7:0] of the same channel.
- R5: Channel pairs are sent in ascending index order, starting from channel 0 and ending at channel N_CH-1, where channel c occupies bits [10c+9:10c] of `samples_i`.
- R6: After the last channel pair, the frame sends 8'hFF and then 8'h00, for 2*N_CH+3 bytes in total, and then ends.
- R7: Channel values are captured at the accepted start pulse. Changes on `samples_i` during a frame do not alter the bytes sent.
- R8: While `valid_o` is high and `ready_i` is low, `data_o` holds its value. The next byte is presented only after a cycle with `valid_o` and `ready_i` both high.
- R9: A start pulse that arrives while `busy_o` is high is ignored. No second frame follows the current one.
- R10: `busy_o` rises in the cycle after the accepted start. It falls in the cycle after the final 8'h00 byte is accepted, and `valid_o` falls with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; acted on only when idle |
| samples_i | input | N_CH*10 | Channel readings, channel c at bits [10c+9:10c] |
| ready_i | input | 1 | Consumer can take the byte |
| data_o | output | 8 | Byte being offered |
| valid_o | output | 1 | `data_o` holds a frame byte |
| busy_o | output | 1 | Frame in progress |

## Verification
The header byte is due one clock edge after start is sampled. Each following byte is due one edge after the previous byte is accepted, and `busy_o` and `valid_o` drop one edge after the final byte is accepted. The bench drives inputs at the falling edge and samples outputs at the next falling edge, so every check lands half a cycle after the register that produces the value. Stalls insert falling-edge samples with `ready_i` low, which confirm that the byte holds. The start pulses and sample changes injected mid-frame are checked against the bytes that follow and against the idle state after the frame.

// File: rtl/adc_dump_pkg.sv
package adc_dump_pkg;
  localparam int SAMPLE_W = 10;
  localparam int BYTE_W   = 8;
  localparam logic [7:0] HDR_BYTE  = 8'hA0;
  localparam logic [7:0] END_BYTE1 = 8'hFF;
  localparam logic [7:0] END_BYTE0 = 8'h00;

  typedef enum logic [2:0] {
    K_HDR,
    K_HI,
    K_LO,
    K_END1,
    K_END0
  } byte_kind_e;
endpackage

// File: rtl/adc_dump_snapshot.sv
module adc_dump_snapshot
  import adc_dump_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int TOT_W = N_CH * SAMPLE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [TOT_W-1:0] samples_i,
  output logic [TOT_W-1:0] snap_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q <= '0;
      else if (cap_i) q <= samples_i[c*SAMPLE_W +: SAMPLE_W];
    end
    assign snap_o[c*SAMPLE_W +: SAMPLE_W] = q;
  end

  // R7: snapshot only moves on capture
  p_snap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(snap_o));
endmodule

// File: rtl/adc_dump_seq.sv
module adc_dump_seq
  import adc_dump_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int LAST  = 2 * N_CH + 2,
  localparam int IDX_W = $clog2(LAST + 1),
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            ready_i,
  output logic            busy_o,
  output logic            cap_o,
  output byte_kind_e      kind_o,
  output logic [CH_W-1:0] ch_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire, last;

  assign cap_o = start_i & ~busy_q;
  assign fire  = busy_q & ready_i;
  assign last  = (idx_q == IDX_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (cap_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (fire) begin
      busy_q <= ~last;
      idx_q  <= last ? '0 : idx_q + 1'b1;
    end
  end

  always_comb begin
    if (idx_q == '0)                            kind_o = K_HDR;
    else if (idx_q == IDX_W'(LAST - 1))         kind_o = K_END1;
    else if (last)                              kind_o = K_END0;
    else if (idx_q[0])                          kind_o = K_HI;
    else                                        kind_o = K_LO;
  end

  logic [IDX_W-1:0] pos;
  assign pos  = idx_q - 1'b1;
  assign ch_o = CH_W'(pos >> 1);
  assign busy_o = busy_q;

  p_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && last |=> !busy_o);
  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !ready_i |=> busy_q && $stable(idx_q));
  p_idx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q <= IDX_W'(LAST));
endmodule

// File: rtl/adc_dump_byte_sel.sv
module adc_dump_byte_sel
  import adc_dump_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int TOT_W = N_CH * SAMPLE_W,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  byte_kind_e       kind_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [TOT_W-1:0] snap_i,
  output logic [7:0]       data_o
);
  logic [SAMPLE_W-1:0] smp;

  always_comb begin
    smp = '0;
    for (int c = 0; c < N_CH; c++)
      if (int'(ch_i) == c) smp = snap_i[c*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    unique case (kind_i)
      K_HDR:   data_o = HDR_BYTE;
      K_HI:    data_o = {6'b0, smp[9:8]};
      K_LO:    data_o = smp[7:0];
      K_END1:  data_o = END_BYTE1;
      default: data_o = END_BYTE0;
    endcase
  end
endmodule

// File: rtl/adc_dump_framer.sv
module adc_dump_framer
  import adc_dump_pkg::*;
#(
  parameter int N_CH = 8,
  localparam int TOT_W = N_CH * SAMPLE_W,
  localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TOT_W-1:0] samples_i,
  input  logic             ready_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             busy_o
);
  logic             cap;
  byte_kind_e       kind;
  logic [CH_W-1:0]  ch;
  logic [TOT_W-1:0] snap;

  adc_dump_seq #(.N_CH(N_CH)) u_seq (
    .clk_i, .rst_ni, .start_i, .ready_i,
    .busy_o, .cap_o(cap), .kind_o(kind), .ch_o(ch)
  );

  adc_dump_snapshot #(.N_CH(N_CH)) u_snap (
    .clk_i, .rst_ni, .cap_i(cap), .samples_i, .snap_o(snap)
  );

  adc_dump_byte_sel #(.N_CH(N_CH)) u_sel (
    .kind_i(kind), .ch_i(ch), .snap_i(snap), .data_o
  );

  assign valid_o = busy_o;

  p_header_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> valid_o && data_o == HDR_BYTE);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));
  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !ready_i |=> busy_o && $stable(data_o));
endmodule

// File: tb/adc_dump_framer_bench.sv
module adc_dump_framer_bench;
  localparam int N = 4;
  localparam int NB = 2 * N + 3;

  logic clk = 0, rst_n = 0, start = 0, ready = 0;
  logic [N*10-1:0] samples = '0;
  logic [7:0] data;
  logic valid, busy;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_dump_framer #(.N_CH(N)) u_adc_dump_framer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .samples_i(samples),
    .ready_i(ready), .data_o(data), .valid_o(valid), .busy_o(busy)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, logic [N*10-1:0] v);
    int c;
    if (k == 0) return 8'hA0;
    if (k == NB - 2) return 8'hFF;
    if (k == NB - 1) return 8'h00;
    c = (k - 1) / 2;
    if (k % 2 == 1) return {6'b0, v[c*10+8 +: 2]};
    return v[c*10 +: 8];
  endfunction

  // one frame; stall pattern and mid-frame disturbance selected by f
  task automatic run_frame(int f, logic [N*10-1:0] v);
    samples = v;
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R10 busy after start", busy, 1);
    for (int k = 0; k < NB; k++) begin
      chk($sformatf("R2-R6 byte %0d valid", k), valid, 1);
      chk($sformatf("R3/R4/R5/R6/R2 byte %0d f%0d", k, f), data, exp_byte(k, v));
      if ((k + f) % 3 == 1) begin
        ready = 0;
        if (k == 2) start = 1; // R9 stray start during frame
        @(negedge clk);
        start = 0;
        chk("R8 hold valid", valid, 1);
        chk("R8 hold data", data, exp_byte(k, v));
      end
      if (k == 3) samples = ~v; // R7 inputs change mid-frame
      if (k == 4) start = 1;   // R9 start while accepting
      ready = 1;
      @(negedge clk);
      start = 0;
      ready = 0;
    end
    chk("R10 busy falls after 00", busy, 0);
    chk("R10 valid falls", valid, 0);
    @(negedge clk);
    chk("R9 no second frame", busy, 0);
  endtask

  initial begin
    ready = 0;
    @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", valid, 0);
    chk("R1 busy after reset", busy, 0);
    run_frame(0, '0);
    run_frame(1, '1);
    run_frame(2, {N{10'h2AA}});
    run_frame(3, {N{10'h155}});
    for (int f = 4; f < 40; f++) begin
      logic [N*10-1:0] v;
      for (int c = 0; c < N; c++) v[c*10 +: 10] = 10'((f * 97 + c * 331 + f * c * 13) % 1024);
      run_frame(f, v);
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule